// File: doc/BRIEF.md
# DMA Page Address Extension Unit

This unit widens the 16-bit address counters of a DMA controller onto a wider system address bus. Each channel owns a page register, written by the CPU through an indexed write port. On every bus cycle the controller presents the active channel and its current counter value. One clock later, the unit returns the full system address, made from that channel's page and the counter value.

A parameter mask declares each channel as a byte channel or a word channel. A byte channel places its 8-bit page above the 16-bit counter value. A word channel shifts the counter left by one bit, so it only ever produces even addresses, and it drops the counter's top bit. DMA activity never changes a page register. A transfer whose counter rolls over therefore wraps inside its own 64 KiB block and does not carry into the page. Software must split transfers at block boundaries.

Top module: `pgx_addr_ext`

## Requirements
- R1: While `rst` is high, every page register returns to zero, `addr_vld` is 0 and `addr` is 0. A lookup made after reset, before any page write, returns page 0x00.
- R2: For a byte channel, the address captured after a lookup is {page, req_ofs}. Bits 15:0 equal the offset and bits 23:16 equal the channel's page.
- R3: For a word channel, the address captured is {page, req_ofs[14:0], 0}. Bit 0 is always 0, and `req_ofs[15]` has no effect on the address.
- R4: A channel is a word channel when its bit in `WORD_MASK` is 1. The default is 8'hF0, so channels 4 to 7 are word channels and 0 to 3 are byte channels. `addr_word` reports the type of the channel looked up.
- R5: `addr_vld` is high exactly one clock after a cycle with `req` high. When `req` is low, `addr_vld` falls and `addr` and `addr_word` keep their previous values.
- R6: A cycle with `pg_we` high stores `pg_wdata` into the page register of channel `pg_widx`. The page registers of all other channels are unchanged.
- R7: When a page write and a lookup of the same channel occur in the same cycle, the lookup uses the page value from before the write. The new page applies from the next lookup onward.
- R8: A page never changes because of the offsets presented. With page 0x03, an ascending run of 256 byte offsets from 0xFF8C yields 0x03FF8C up to 0x03FFFF and then 0x030000 up to 0x03008B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_we | input | 1 | Page register write strobe |
| pg_widx | input | 3 | Channel whose page is written |
| pg_wdata | input | 8 | Page value to store |
| req | input | 1 | Address lookup request for this cycle |
| req_ch | input | 3 | Channel being serviced |
| req_ofs | input | 16 | Channel's current counter value |
| addr_vld | output | 1 | Registered: `addr` holds a fresh result |
| addr | output | 24 | Registered system address |
| addr_word | output | 1 | Registered: looked-up channel is a word channel |

## Verification
The hardest case to reach is a page write colliding with a lookup of the same channel in the same cycle. The bench drives both strobes on one falling edge. It then checks that the first result still carries the old page and that the following lookup carries the new one. The rollover of a counter inside its block is reached by walking 256 consecutive offsets across 0xFFFF on a byte channel. The dropped top bit on word channels is reached by offset pairs that differ only in bit 15.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PGX_NUM_CH = 8;
  localparam int PGX_PAGE_W = 8;
  localparam int PGX_OFS_W  = 16;

  typedef enum logic {
    CH_BYTE = 1'b0,
    CH_WORD = 1'b1
  } ch_kind_e;
endpackage

// File: rtl/pgx_page_file.sv
module pgx_page_file #(
  parameter int NUM_CH = 8,
  parameter int PAGE_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   widx,
  input  logic [PAGE_W-1:0] wdata,
  input  logic [CH_W-1:0]   ridx,
  output logic [PAGE_W-1:0] rdata
);
  logic [PAGE_W-1:0] pg_q [NUM_CH];

  // Read is combinational from the array; a same-cycle write lands after
  // the edge, so a lookup in that cycle sees the old value.
  assign rdata = pg_q[ridx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) pg_q[i] <= '0;
    end else if (we) begin
      pg_q[widx] <= wdata;
    end
  end
endmodule

// File: rtl/pgx_kind_dec.sv
module pgx_kind_dec
  import pgx_pkg::*;
#(
  parameter int          NUM_CH    = 8,
  parameter logic [NUM_CH-1:0] WORD_MASK = 8'hF0,
  localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [CH_W-1:0] ch,
  output ch_kind_e        kind
);
  ch_kind_e kind_tab [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_kind
    if (WORD_MASK[g]) begin : g_word
      assign kind_tab[g] = CH_WORD;
    end else begin : g_byte
      assign kind_tab[g] = CH_BYTE;
    end
  end

  assign kind = kind_tab[ch];
endmodule

// File: rtl/pgx_compose.sv
module pgx_compose
  import pgx_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  ch_kind_e          kind,
  output logic [ADDR_W-1:0] addr
);
  logic [OFS_W-1:0] low_byte;
  logic [OFS_W-1:0] low_word;

  assign low_byte = ofs;
  assign low_word = {ofs[OFS_W-2:0], 1'b0};

  always_comb begin
    unique case (kind)
      CH_WORD: addr = {page, low_word};
      default: addr = {page, low_byte};
    endcase
  end
endmodule

// File: rtl/pgx_addr_ext.sv
module pgx_addr_ext
  import pgx_pkg::*;
#(
  parameter int                NUM_CH    = PGX_NUM_CH,
  parameter int                PAGE_W    = PGX_PAGE_W,
  parameter int                OFS_W     = PGX_OFS_W,
  parameter logic [NUM_CH-1:0] WORD_MASK = 8'hF0,
  localparam int               CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int               ADDR_W    = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_we,
  input  logic [CH_W-1:0]   pg_widx,
  input  logic [PAGE_W-1:0] pg_wdata,
  input  logic              req,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [OFS_W-1:0]  req_ofs,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_word
);
  logic [PAGE_W-1:0] cur_page;
  ch_kind_e          cur_kind;
  logic [ADDR_W-1:0] cur_addr;

  pgx_page_file #(.NUM_CH(NUM_CH), .PAGE_W(PAGE_W)) u_pf (
    .clk   (clk),
    .rst   (rst),
    .we    (pg_we),
    .widx  (pg_widx),
    .wdata (pg_wdata),
    .ridx  (req_ch),
    .rdata (cur_page)
  );

  pgx_kind_dec #(.NUM_CH(NUM_CH), .WORD_MASK(WORD_MASK)) u_kd (
    .ch   (req_ch),
    .kind (cur_kind)
  );

  pgx_compose #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_cmp (
    .page (cur_page),
    .ofs  (req_ofs),
    .kind (cur_kind),
    .addr (cur_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_vld  <= 1'b0;
      addr      <= '0;
      addr_word <= 1'b0;
    end else begin
      addr_vld <= req;
      if (req) begin
        addr      <= cur_addr;
        addr_word <= (cur_kind == CH_WORD);
      end
    end
  end
endmodule

// File: rtl/pgx_addr_ext_chk.sv
module pgx_addr_ext_chk #(
  parameter int                NUM_CH    = 8,
  parameter int                PAGE_W    = 8,
  parameter int                OFS_W     = 16,
  parameter logic [NUM_CH-1:0] WORD_MASK = 8'hF0,
  localparam int               CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int               ADDR_W    = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic [CH_W-1:0]   req_ch,
  input logic [OFS_W-1:0]  req_ofs,
  input logic              addr_vld,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_word
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!addr_vld && addr == '0));

  // R5
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (addr_vld == $past(req)));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(addr) && $stable(addr_word)));

  // R2
  byte_low_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && !addr_word) |-> (addr[OFS_W-1:0] == $past(req_ofs)));

  // R3
  word_even_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && addr_word) |-> (addr[0] == 1'b0 &&
      addr[OFS_W-1:1] == $past(req_ofs[OFS_W-2:0])));

  // R4
  kind_map_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld |-> (addr_word == WORD_MASK[$past(req_ch)]));
endmodule

bind pgx_addr_ext pgx_addr_ext_chk #(
  .NUM_CH(NUM_CH), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .WORD_MASK(WORD_MASK)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .req_ch(req_ch), .req_ofs(req_ofs),
  .addr_vld(addr_vld), .addr(addr), .addr_word(addr_word)
);

// File: tb/sim_pgx_addr_ext.sv
module sim_pgx_addr_ext;
  logic        clk = 1'b0;
  logic        rst;
  logic        pg_we;
  logic [2:0]  pg_widx;
  logic [7:0]  pg_wdata;
  logic        req;
  logic [2:0]  req_ch;
  logic [15:0] req_ofs;
  logic        addr_vld;
  logic [23:0] addr;
  logic        addr_word;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pgx_addr_ext u0 (
    .clk(clk), .rst(rst), .pg_we(pg_we), .pg_widx(pg_widx),
    .pg_wdata(pg_wdata), .req(req), .req_ch(req_ch), .req_ofs(req_ofs),
    .addr_vld(addr_vld), .addr(addr), .addr_word(addr_word)
  );

  // {channel, offset, expected address}; pages set by program_pages
  localparam logic [42:0] VEC [15] = '{
    {3'd0, 16'hFF8C, 24'h03FF8C},  // R2
    {3'd0, 16'hFFFF, 24'h03FFFF},  // R8
    {3'd0, 16'h0000, 24'h030000},  // R8
    {3'd0, 16'h008B, 24'h03008B},  // R2
    {3'd1, 16'h1234, 24'h121234},  // R2
    {3'd2, 16'h0001, 24'h7E0001},  // R2
    {3'd3, 16'hABCD, 24'hFFABCD},  // R2
    {3'd4, 16'h0001, 24'h050002},  // R3
    {3'd4, 16'h8001, 24'h050002},  // R3
    {3'd5, 16'h7FFF, 24'h80FFFE},  // R3
    {3'd5, 16'hFFFF, 24'h80FFFE},  // R3
    {3'd6, 16'h1234, 24'hA12468},  // R3
    {3'd7, 16'h4000, 24'h008000},  // R3
    {3'd7, 16'hC000, 24'h008000},  // R3
    {3'd3, 16'h0000, 24'hFF0000}   // R2
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_page(input logic [2:0] ch, input logic [7:0] val);
    @(negedge clk);
    pg_we = 1'b1; pg_widx = ch; pg_wdata = val;
    @(negedge clk);
    pg_we = 1'b0;
  endtask

  // Drive one lookup, then sample after the capturing edge.
  task automatic lookup(input logic [2:0] ch, input logic [15:0] ofs);
    @(negedge clk);
    req = 1'b1; req_ch = ch; req_ofs = ofs;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; pg_we = 1'b0; pg_widx = '0; pg_wdata = '0;
    req = 1'b0; req_ch = '0; req_ofs = '0;
    repeat (3) @(negedge clk);
    check("R1 vld in reset", {31'd0, addr_vld}, 32'd0);
    check("R1 addr in reset", {8'd0, addr}, 32'd0);
    rst = 1'b0;

    // R1: pages start at zero
    lookup(3'd2, 16'h0055);
    check("R1 page zero after reset", {8'd0, addr}, 32'h000055);
    check("R5 vld after req", {31'd0, addr_vld}, 32'd1);

    // program pages
    wr_page(3'd0, 8'h03); wr_page(3'd1, 8'h12);
    wr_page(3'd2, 8'h7E); wr_page(3'd3, 8'hFF);
    wr_page(3'd4, 8'h05); wr_page(3'd5, 8'h80);
    wr_page(3'd6, 8'hA1); wr_page(3'd7, 8'h00);

    // R5: idle cycle drops vld and holds addr
    check("R5 vld idle", {31'd0, addr_vld}, 32'd0);
    check("R5 addr held", {8'd0, addr}, 32'h000055);

    for (int i = 0; i < 15; i++) begin
      lookup(VEC[i][42:40], VEC[i][39:24]);
      check("R2/R3 table addr", {8'd0, addr}, {8'd0, VEC[i][23:0]});
      // R4: channels 4..7 are word channels
      check("R4 word flag", {31'd0, addr_word},
            {31'd0, (VEC[i][42:40] >= 3'd4)});
    end

    // R8: 256 ascending byte offsets wrap inside page 0x03
    for (int k = 0; k < 256; k++) begin
      logic [15:0] o;
      o = 16'hFF8C + k[15:0];
      @(negedge clk);
      req = 1'b1; req_ch = 3'd0; req_ofs = o;
      @(negedge clk);
      check("R8 wrap walk", {8'd0, addr}, {8'h00, 8'h03, o});
    end
    req = 1'b0;
    check("R8 last address", {8'd0, addr}, 32'h03008B);

    // R6: write one channel, others keep their pages
    wr_page(3'd1, 8'h44);
    lookup(3'd1, 16'h0010);
    check("R6 written channel", {8'd0, addr}, 32'h440010);
    lookup(3'd2, 16'h0010);
    check("R6 neighbour unchanged", {8'd0, addr}, 32'h7E0010);

    // R7: same-cycle write and lookup of one channel
    @(negedge clk);
    pg_we = 1'b1; pg_widx = 3'd3; pg_wdata = 8'h22;
    req = 1'b1; req_ch = 3'd3; req_ofs = 16'h0010;
    @(negedge clk);
    pg_we = 1'b0; req = 1'b0;
    check("R7 old page used", {8'd0, addr}, 32'hFF0010);
    lookup(3'd3, 16'h0010);
    check("R7 new page next", {8'd0, addr}, 32'h220010);

    // R1: reset again clears pages
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 vld after reset", {31'd0, addr_vld}, 32'd0);
    lookup(3'd6, 16'h0003);
    check("R1 word page cleared", {8'd0, addr}, 32'h000006);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule